// File: doc/BRIEF.md
# PLL Multiplier Parameter Solver

This block is a sequential search engine that turns a reference frequency and a wanted PLL output frequency into the three PLL settings: a post-divider `pd`, an integer multiplier `mfi` and a fractional numerator `mfn`. The fractional denominator `mfd` is fixed, and its value is chosen by a reference-select flag. The settings satisfy out = 2 * ref * (mfi + mfn / mfd) / pd, where `pd` and `mfd` are actual divisor values and not register-minus-one codes.

A caller places the two frequencies and the two flags on the inputs and pulses `start_i` for one cycle while the engine is idle. The engine first checks the target against the reachable window. It then walks the post-divider upward and uses one shared bit-serial divider for every quotient. When it finishes, it posts a one-cycle `done_o` together with either a solution or an error code. The posted values stay on the outputs until the next completion.

The FSM has these states: `S_IDLE` waits for a start. `S_RANGE` checks the window. `S_MFI_GO` and `S_MFI_WAIT` launch and collect the multiplier quotient. `S_MFN_GO` and `S_MFN_WAIT` launch and collect the numerator quotient. `S_STEP` moves to the next post-divider. The transitions are:
- start in idle goes to range.
- An out-of-window result in range goes back to idle with an error.
- An in-window result goes to the multiplier launch, and the launch goes to its wait.
- A multiplier in bounds goes to the numerator launch. Out of bounds goes to step.
- The numerator launch goes to its wait.
- A fitting numerator goes to idle with a solution. A numerator that does not fit goes to step.
- In step, the last post-divider goes to idle with a no-solution error. Any other value returns to the multiplier launch.

Top module: `pll_solver`

## Requirements
- R1: After reset, `done_o` is 0, `err_o` is 0, and `pd_o`, `mfi_o`, `mfn_o` and `mfd_o` are all 0.
- R2: If `ref_hz_i` is 0, or the target is below floor(2*ref*6/16) or above 2*ref*15, the result is `err_o` = 1 (range error) with all four settings 0. Both window bounds are inclusive.
- R3: The post-divider is tried in increasing order from 1 to 16. The result is the first pd whose mfi = floor(target*pd/(2*ref)) lies in 6..15 inclusive and whose numerator fits (R6). A solution reports `err_o` = 0.
- R4: For the chosen pd, mfn = floor((floor(target*pd/2) - ref*mfi) * mfd / ref), computed exactly with no truncation of any intermediate product.
- R5: `mfd` is 416 when `ref_sel_i` = 0 and 432 when `ref_sel_i` = 1.
- R6: A candidate numerator is accepted only if it is below mfd. It must also be at most the first-revision limit (1022 by default) when `rev_first_i` = 1, or at most the later-revision limit (510 by default) when `rev_first_i` = 0. Otherwise that pd is rejected and the search continues.
- R7: If no pd up to 16 gives a fitting pair, the result is `err_o` = 2 (no solution) with all four settings 0.
- R8: `done_o` is high for exactly one cycle per solve. The settings and `err_o` change only in the cycle `done_o` is high and stay unchanged until the next `done_o`.
- R9: A start is accepted only while the engine is idle, and this includes the cycle in which `done_o` is high. A start during a search is ignored, and the search in progress completes with its own latched inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to solve |
| ref_hz_i | input | 32 | Reference frequency in Hz |
| target_hz_i | input | 32 | Wanted PLL output frequency in Hz |
| ref_sel_i | input | 1 | Denominator select: 0 gives 416, 1 gives 432 |
| rev_first_i | input | 1 | 1 selects the first-revision numerator limit |
| pd_o | output | 5 | Post-divider (actual divisor) |
| mfi_o | output | 4 | Integer multiplier |
| mfn_o | output | 10 | Fractional numerator |
| mfd_o | output | 9 | Fractional denominator (actual divisor) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | 0 solved, 1 range error, 2 no solution |

## Verification
Two functions can fall in the same cycle: posting a finished result and accepting a new start. The engine is back in idle in the very cycle `done_o` is high. The bench watches for that pulse and drives `start_i` in the same cycle with a different request. It then checks two things: in the following cycle the previously posted settings are still present with `done_o` low, and the next completion carries the new request's answer. A start issued in the middle of a search is checked the same way. Its answer must never appear, and the original request's answer must.

// File: rtl/pll_solver_pkg.sv
package pll_solver_pkg;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_RANGE = 2'd1,
        ERR_NOFIT = 2'd2
    } solve_err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RANGE,
        S_MFI_GO,
        S_MFI_WAIT,
        S_MFN_GO,
        S_MFN_WAIT,
        S_STEP
    } solve_state_e;

endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
    parameter int NW = 42,
    parameter int DW = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [NW-1:0] quo_o
);
    localparam int CW = $clog2(NW + 1);

    logic [DW-1:0] rem_q, den_q;
    logic [NW-1:0] quo_q;
    logic [CW-1:0] cnt_q;
    logic [DW:0]   rem_sh, rem_sub;
    logic          take;

    assign rem_sh  = {rem_q, quo_q[NW-1]};
    assign take    = rem_sh >= {1'b0, den_q};
    assign rem_sub = rem_sh - {1'b0, den_q};
    assign quo_o   = quo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                rem_q  <= '0;
                den_q  <= den_i;
                quo_q  <= num_i;
                cnt_q  <= CW'(NW);
                busy_o <= 1'b1;
            end else if (busy_o) begin
                rem_q <= take ? rem_sub[DW-1:0] : rem_sh[DW-1:0];
                quo_q <= {quo_q[NW-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    AST_DIV_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy_o);                                     // R9
    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && den_q != '0) |-> rem_q < den_q);             // R4

endmodule

// File: rtl/pll_window_chk.sv
module pll_window_chk #(
    parameter int FW      = 32,
    parameter int MFI_MIN = 6,
    parameter int MFI_MAX = 15,
    parameter int PD_MAX  = 16
) (
    input  logic [FW-1:0] ref_i,
    input  logic [FW-1:0] tgt_i,
    output logic          bad_o
);
    localparam int WW = FW + 8;

    logic [WW-1:0] lo, hi, tgt_w;

    always_comb begin
        lo    = (WW'(ref_i) * WW'(2 * MFI_MIN)) / WW'(PD_MAX);
        hi    = WW'(ref_i) * WW'(2 * MFI_MAX);
        tgt_w = WW'(tgt_i);
        bad_o = (ref_i == '0) || (tgt_w < lo) || (tgt_w > hi);
    end

endmodule

// File: rtl/pll_limit_sel.sv
module pll_limit_sel #(
    parameter int MFD_A    = 416,
    parameter int MFD_B    = 432,
    parameter int LIM_R1   = 1022,
    parameter int LIM_R2   = 510,
    parameter int MFDW     = 9,
    parameter int MFNW     = 10
) (
    input  logic            sel_i,
    input  logic            rev_first_i,
    output logic [MFDW-1:0] mfd_o,
    output logic [MFNW-1:0] lim_o
);
    assign mfd_o = sel_i       ? MFDW'(MFD_B)  : MFDW'(MFD_A);
    assign lim_o = rev_first_i ? MFNW'(LIM_R1) : MFNW'(LIM_R2);

endmodule

// File: rtl/pll_solver.sv
module pll_solver
    import pll_solver_pkg::*;
#(
    parameter int FW         = 32,
    parameter int PD_MAX     = 16,
    parameter int MFI_MIN    = 6,
    parameter int MFI_MAX    = 15,
    parameter int MFN_LIM_R1 = 1022,
    parameter int MFN_LIM_R2 = 510,
    parameter int MFD_REF_A  = 416,
    parameter int MFD_REF_B  = 432
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [FW-1:0]                         ref_hz_i,
    input  logic [FW-1:0]                         target_hz_i,
    input  logic                                  ref_sel_i,
    input  logic                                  rev_first_i,
    output logic [$clog2(PD_MAX+1)-1:0]           pd_o,
    output logic [$clog2(MFI_MAX+1)-1:0]          mfi_o,
    output logic [$clog2(MFN_LIM_R1+1)-1:0]       mfn_o,
    output logic [$clog2(((MFD_REF_B > MFD_REF_A) ? MFD_REF_B : MFD_REF_A)+1)-1:0] mfd_o,
    output logic                                  done_o,
    output logic [1:0]                            err_o
);
    localparam int PDW  = $clog2(PD_MAX + 1);
    localparam int MFIW = $clog2(MFI_MAX + 1);
    localparam int MFNW = $clog2(MFN_LIM_R1 + 1);
    localparam int MFDW = $clog2(((MFD_REF_B > MFD_REF_A) ? MFD_REF_B : MFD_REF_A) + 1);
    localparam int NW   = FW + MFDW + PDW;
    localparam int DW   = FW + 1;

    solve_state_e state_q, state_d;

    logic [FW-1:0]   ref_q, tgt_q;
    logic            sel_q, rev_q;
    logic [PDW-1:0]  pd_q;
    logic [MFIW-1:0] mfi_q;

    logic            div_go, div_busy, div_done;
    logic [NW-1:0]   div_num, div_quo;
    logic [DW-1:0]   div_den;

    logic            out_of_window;
    logic [MFDW-1:0] mfd_sel;
    logic [MFNW-1:0] mfn_lim;

    logic [NW-1:0]   prod, half, base, frac, mfn_num;
    logic            mfi_fit, mfn_fit, last_pd;
    logic            fin_ok, fin_range, fin_nofit;

    pll_window_chk #(
        .FW(FW), .MFI_MIN(MFI_MIN), .MFI_MAX(MFI_MAX), .PD_MAX(PD_MAX)
    ) u_window (
        .ref_i (ref_q),
        .tgt_i (tgt_q),
        .bad_o (out_of_window)
    );

    pll_limit_sel #(
        .MFD_A(MFD_REF_A), .MFD_B(MFD_REF_B),
        .LIM_R1(MFN_LIM_R1), .LIM_R2(MFN_LIM_R2),
        .MFDW(MFDW), .MFNW(MFNW)
    ) u_limit (
        .sel_i       (sel_q),
        .rev_first_i (rev_q),
        .mfd_o       (mfd_sel),
        .lim_o       (mfn_lim)
    );

    pll_div_seq #(.NW(NW), .DW(DW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go),
        .num_i  (div_num),
        .den_i  (div_den),
        .busy_o (div_busy),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    // numerator datapath
    always_comb begin
        prod    = NW'(tgt_q) * NW'(pd_q);
        half    = prod >> 1;
        base    = NW'(ref_q) * NW'(mfi_q);
        frac    = half - base;
        mfn_num = frac * NW'(mfd_sel);
    end

    assign mfi_fit = (div_quo >= NW'(MFI_MIN)) && (div_quo <= NW'(MFI_MAX));
    assign mfn_fit = (div_quo <= NW'(mfn_lim)) && (div_quo < NW'(mfd_sel));
    assign last_pd = (pd_q == PDW'(PD_MAX));

    assign div_go  = (state_q == S_MFI_GO) || (state_q == S_MFN_GO);
    assign div_num = (state_q == S_MFN_GO) ? mfn_num : prod;
    assign div_den = (state_q == S_MFN_GO) ? DW'(ref_q) : {ref_q, 1'b0};

    // next state
    always_comb begin
        state_d   = state_q;
        fin_ok    = 1'b0;
        fin_range = 1'b0;
        fin_nofit = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = S_RANGE;
            end
            S_RANGE: begin
                if (out_of_window) begin
                    fin_range = 1'b1;
                    state_d   = S_IDLE;
                end else begin
                    state_d = S_MFI_GO;
                end
            end
            S_MFI_GO: state_d = S_MFI_WAIT;
            S_MFI_WAIT: begin
                if (div_done) state_d = mfi_fit ? S_MFN_GO : S_STEP;
            end
            S_MFN_GO: state_d = S_MFN_WAIT;
            S_MFN_WAIT: begin
                if (div_done) begin
                    if (mfn_fit) begin
                        fin_ok  = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        state_d = S_STEP;
                    end
                end
            end
            S_STEP: begin
                if (last_pd) begin
                    fin_nofit = 1'b1;
                    state_d   = S_IDLE;
                end else begin
                    state_d = S_MFI_GO;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // working registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= '0;
            tgt_q  <= '0;
            sel_q  <= 1'b0;
            rev_q  <= 1'b0;
            pd_q   <= '0;
            mfi_q  <= '0;
            pd_o   <= '0;
            mfi_o  <= '0;
            mfn_o  <= '0;
            mfd_o  <= '0;
            err_o  <= ERR_NONE;
            done_o <= 1'b0;
        end else begin
            done_o <= fin_ok | fin_range | fin_nofit;
            if (state_q == S_IDLE && start_i) begin
                ref_q <= ref_hz_i;
                tgt_q <= target_hz_i;
                sel_q <= ref_sel_i;
                rev_q <= rev_first_i;
                pd_q  <= PDW'(1);
            end
            if (state_q == S_MFI_WAIT && div_done && mfi_fit)
                mfi_q <= div_quo[MFIW-1:0];
            if (state_q == S_STEP && !last_pd)
                pd_q <= pd_q + 1'b1;
            if (fin_ok) begin
                pd_o  <= pd_q;
                mfi_o <= mfi_q;
                mfn_o <= div_quo[MFNW-1:0];
                mfd_o <= mfd_sel;
                err_o <= ERR_NONE;
            end else if (fin_range || fin_nofit) begin
                pd_o  <= '0;
                mfi_o <= '0;
                mfn_o <= '0;
                mfd_o <= '0;
                err_o <= fin_range ? ERR_RANGE : ERR_NOFIT;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                              // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({pd_o, mfi_o, mfn_o, mfd_o, err_o}));         // R8
    AST_PD_MFI_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == ERR_NONE) |->
            (pd_o >= PDW'(1) && pd_o <= PDW'(PD_MAX) &&
             mfi_o >= MFIW'(MFI_MIN) && mfi_o <= MFIW'(MFI_MAX)));        // R3
    AST_MFN_BELOW_MFD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == ERR_NONE) |-> mfn_o < MFNW'(mfd_o));          // R6
    AST_MFN_REV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == ERR_NONE && !rev_q) |-> mfn_o <= MFNW'(MFN_LIM_R2)); // R6
    AST_MFD_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == ERR_NONE) |->
            mfd_o == (sel_q ? MFDW'(MFD_REF_B) : MFDW'(MFD_REF_A)));      // R5
    AST_ERR_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o != ERR_NONE) |-> (pd_o == '0 && mfd_o == '0));   // R2
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && !div_busy && state_q == S_RANGE) |=> state_q != S_RANGE); // R9

endmodule

// File: tb/pll_solver_bench.sv
module pll_solver_bench;

    typedef struct packed {
        logic [31:0] rf;
        logic [31:0] tg;
        logic        sel;
        logic        rev;
        logic [4:0]  pd;
        logic [3:0]  mfi;
        logic [9:0]  mfn;
        logic [8:0]  mfd;
        logic [1:0]  err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VTAB [NV] = '{
        '{32'd26000000, 32'd266000000, 1'b0, 1'b1, 5'd2,  4'd10, 10'd96,  9'd416, 2'd0},
        '{32'd26000000, 32'd399000000, 1'b0, 1'b0, 5'd1,  4'd7,  10'd280, 9'd416, 2'd0},
        '{32'd27000000, 32'd350000000, 1'b1, 1'b1, 5'd1,  4'd6,  10'd208, 9'd432, 2'd0},
        '{32'd27000000, 32'd100000000, 1'b1, 1'b1, 5'd4,  4'd7,  10'd176, 9'd432, 2'd0},
        '{32'd26000000, 32'd123456789, 1'b0, 1'b1, 5'd3,  4'd7,  10'd50,  9'd416, 2'd0},
        '{32'd26000000, 32'd780000000, 1'b0, 1'b0, 5'd1,  4'd15, 10'd0,   9'd416, 2'd0},
        '{32'd26000000, 32'd19500000,  1'b0, 1'b1, 5'd16, 4'd6,  10'd0,   9'd416, 2'd0},
        '{32'd26000000, 32'd781000000, 1'b0, 1'b1, 5'd0,  4'd0,  10'd0,   9'd0,   2'd1},
        '{32'd26000000, 32'd19499999,  1'b0, 1'b1, 5'd0,  4'd0,  10'd0,   9'd0,   2'd1},
        '{32'd0,        32'd100000000, 1'b0, 1'b1, 5'd0,  4'd0,  10'd0,   9'd0,   2'd1},
        '{32'd26000000, 32'd100000000, 1'b0, 1'b1, 5'd4,  4'd7,  10'd288, 9'd416, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_hz = '0, tgt_hz = '0;
    logic        sel = 1'b0, rev = 1'b0;

    logic [4:0] pd_m, pd_t;
    logic [3:0] mfi_m, mfi_t;
    logic [9:0] mfn_m, mfn_t;
    logic [8:0] mfd_m, mfd_t;
    logic       done_m, done_t;
    logic [1:0] err_m, err_t;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pll_solver u_pll_solver (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ref_hz_i(ref_hz),
        .target_hz_i(tgt_hz), .ref_sel_i(sel), .rev_first_i(rev),
        .pd_o(pd_m), .mfi_o(mfi_m), .mfn_o(mfn_m), .mfd_o(mfd_m),
        .done_o(done_m), .err_o(err_m)
    );

    // same engine with a tight later-revision numerator limit
    pll_solver #(.MFN_LIM_R2(100)) u_pll_solver_tight (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ref_hz_i(ref_hz),
        .target_hz_i(tgt_hz), .ref_sel_i(sel), .rev_first_i(rev),
        .pd_o(pd_t), .mfi_o(mfi_t), .mfn_o(mfn_t), .mfd_o(mfd_t),
        .done_o(done_t), .err_o(err_t)
    );

    task automatic chk(string req, string what, longint got, longint exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic drive(vec_t v);
        ref_hz = v.rf;
        tgt_hz = v.tg;
        sel    = v.sel;
        rev    = v.rev;
    endtask

    task automatic launch(vec_t v);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_both();
        bit a = 0;
        bit b = 0;
        int n = 0;
        while (!(a && b) && n < 6000) begin
            if (done_m) a = 1;
            if (done_t) b = 1;
            if (!(a && b)) begin
                @(negedge clk);
                n++;
            end
        end
        if (!(a && b)) chk("R8", "done timeout", 0, 1);
    endtask

    task automatic check_main(vec_t v, string tag);
        string rq;
        rq = (v.err == 2'd1) ? "R2" : "R3";
        chk(rq,   {tag, " err"}, err_m, v.err);
        chk(rq,   {tag, " pd"},  pd_m,  v.pd);
        chk(rq,   {tag, " mfi"}, mfi_m, v.mfi);
        chk((v.err == 2'd1) ? "R2" : "R4", {tag, " mfn"}, mfn_m, v.mfn);
        chk((v.err == 2'd1) ? "R2" : "R5", {tag, " mfd"}, mfd_m, v.mfd);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done", done_m, 0);
        chk("R1", "err",  err_m,  0);
        chk("R1", "pd",   pd_m,   0);
        chk("R1", "mfd",  mfd_m,  0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            launch(VTAB[i]);
            wait_both();
            check_main(VTAB[i], $sformatf("vec%0d", i));
        end

        // R6 and R7: tight limit rejects 280 on later revision and runs out of pd
        launch(VTAB[1]);
        wait_both();
        chk("R6", "main rev0 mfn", mfn_m, 280);
        chk("R7", "tight err", err_t, 2);
        chk("R7", "tight pd",  pd_t,  0);
        chk("R7", "tight mfn", mfn_t, 0);
        begin
            vec_t v;
            v = VTAB[1];
            v.rev = 1'b1;
            launch(v);
            wait_both();
            chk("R6", "tight rev1 err", err_t, 0);
            chk("R6", "tight rev1 mfn", mfn_t, 280);
            chk("R6", "tight rev1 pd",  pd_t,  1);
        end

        // R9: start during a search is ignored
        launch(VTAB[0]);
        repeat (10) @(negedge clk);
        drive(VTAB[7]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_both();
        chk("R9", "busy start err", err_m, 0);
        chk("R9", "busy start pd",  pd_m,  2);
        chk("R9", "busy start mfn", mfn_m, 96);

        // R8/R9 collision: start in the done cycle
        launch(VTAB[3]);
        begin
            int n = 0;
            while (!done_m && n < 6000) begin
                @(negedge clk);
                n++;
            end
        end
        chk("R8", "collision done seen", done_m, 1);
        drive(VTAB[2]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "pulse one cycle", done_m, 0);
        chk("R8", "held pd",  pd_m,  4);
        chk("R8", "held mfn", mfn_m, 176);
        repeat (20) @(negedge clk);
        chk("R8", "held mid-run mfn", mfn_m, 176);
        wait_both();
        chk("R9", "collision start pd",  pd_m,  1);
        chk("R9", "collision start mfi", mfi_m, 6);
        chk("R9", "collision start mfn", mfn_m, 208);
        chk("R5", "collision start mfd", mfd_m, 432);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule